// File: doc/BRIEF.md
# Dual-Mapped Working Register File

This block holds the working registers of a small 8-bit RISC core. The execute stage reads two operands through a pair of combinational read ports, and the ALU result goes back through a single write port at the next clock edge. An operation therefore reads, computes and retires in one cycle. A read always returns the contents from before any write made in that cycle.

The same registers also sit at the bottom of a unified data space, which load/store instructions use. A 64-entry I/O register window follows them in that space, and a separate direct I/O port reaches the same window by its own 0-based index. Data-space addresses above the window are not decoded here. For those, the block raises an external-select output for the memory behind it. The top six registers pair up into three 16-bit address pointers. These pointers are exported continuously and can each be rewritten as a whole in one cycle, as needed for post-increment and pre-decrement addressing.

Top module: `wreg_file`

## Requirements
- R1: A synchronous reset clears all 32 working registers and all 64 I/O registers to zero.
- R2: Two read ports return the 8-bit contents of the registers selected by `rd_a_idx` and `rd_b_idx` combinationally.
- R3: When `alu_we` is high, register `alu_idx` takes `alu_val` at the next rising clock edge.
- R4: Data-space addresses 0x00 to 0x1F read and write working register `ds_addr` when `ds_en` is high (writes also need `ds_we`).
- R5: Data-space addresses 0x20 to 0x5F read and write I/O register `ds_addr - 0x20`, and the direct port reaches the same I/O register at index `io_addr` (0 to 63).
- R6: For data-space addresses of 0x60 and above, `ds_ext_sel` is high while `ds_en` is high and is low otherwise. `ds_rdata` reads zero, and a write changes no register.
- R7: `ptr_x` = {r27, r26}, `ptr_y` = {r29, r28} and `ptr_z` = {r31, r30}, with the lower-numbered register in bits 7:0.
- R8: With `ptr_we` high, `ptr_sel` 0, 1 or 2 writes `ptr_val` into both bytes of X, Y or Z in the same edge. A `ptr_sel` of 3 writes nothing.
- R9: When several writes target one working register in a cycle, the ALU write wins over the pointer write, and the pointer write wins over the data-space write. Writes to other bytes are unaffected.
- R10: When a direct I/O write and a data-space write target one I/O register in a cycle, the direct write wins.
- R11: A register written in a cycle still reads its old value on every read port until the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Operand A register index |
| rd_a_val | output | 8 | Operand A value |
| rd_b_idx | input | 5 | Operand B register index |
| rd_b_val | output | 8 | Operand B value |
| alu_we | input | 1 | ALU write-back enable |
| alu_idx | input | 5 | ALU destination register |
| alu_val | input | 8 | ALU result |
| ds_en | input | 1 | Data-space access strobe |
| ds_we | input | 1 | Data-space write (with ds_en) |
| ds_addr | input | 16 | Data-space byte address |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| ds_ext_sel | output | 1 | Access falls above the I/O window |
| io_we | input | 1 | Direct I/O write enable |
| io_addr | input | 6 | Direct I/O register index |
| io_wdata | input | 8 | Direct I/O write data |
| io_rdata | output | 8 | Direct I/O read data |
| ptr_we | input | 1 | Pointer write enable |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_val | input | 16 | New 16-bit pointer value |
| ptr_x | output | 16 | Pointer X |
| ptr_y | output | 16 | Pointer Y |
| ptr_z | output | 16 | Pointer Z |

## Verification
The bench aims at the window edges 0x1F/0x20, 0x5F/0x60 and 0xFFFF. A decoder off by one there would alias an I/O register onto a working register, or let an external write corrupt the file. It provokes three-way write collisions on pointer registers, where a wrong priority order leaves the data-space byte in place of the ALU or pointer byte. It also provokes collisions where the pointer update lands only one of its two bytes. It samples reads before the edge of a same-cycle write, which catches a design that forwards the new value early. The unused pointer selector must leave all three pointers unchanged.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned GPR_N  = 32;
    localparam int unsigned IO_N   = 64;
    localparam int unsigned DS_AW  = 16;
    localparam int unsigned PTR_N  = 3;

    typedef enum logic [1:0] {
        PTR_X    = 2'd0,
        PTR_Y    = 2'd1,
        PTR_Z    = 2'd2,
        PTR_NONE = 2'd3
    } ptr_sel_e;

    typedef struct packed {
        logic hit_gpr;
        logic hit_io;
        logic hit_ext;
    } ds_region_t;
endpackage

// File: rtl/wreg_ds_decode.sv
module wreg_ds_decode
    import wreg_pkg::*;
#(
    parameter int unsigned GPR_N  = wreg_pkg::GPR_N,
    parameter int unsigned IO_N   = wreg_pkg::IO_N,
    parameter int unsigned DS_AW  = wreg_pkg::DS_AW,
    parameter int unsigned GPR_AW = $clog2(GPR_N),
    parameter int unsigned IO_AW  = $clog2(IO_N)
) (
    input  logic              ds_en,
    input  logic [DS_AW-1:0]  ds_addr,
    output ds_region_t        region,
    output logic [GPR_AW-1:0] gpr_idx,
    output logic [IO_AW-1:0]  io_idx
);
    localparam logic [DS_AW-1:0] IO_BASE  = DS_AW'(GPR_N);
    localparam logic [DS_AW-1:0] EXT_BASE = DS_AW'(GPR_N + IO_N);

    logic [DS_AW-1:0] io_off;

    always_comb begin
        region  = '0;
        io_off  = ds_addr - IO_BASE;
        gpr_idx = ds_addr[GPR_AW-1:0];
        io_idx  = io_off[IO_AW-1:0];
        if (ds_addr < IO_BASE) begin
            region.hit_gpr = 1'b1;
        end else if (ds_addr < EXT_BASE) begin
            region.hit_io = 1'b1;
        end else begin
            region.hit_ext = ds_en;
        end
    end
endmodule

// File: rtl/wreg_gpr_bank.sv
module wreg_gpr_bank #(
    parameter int unsigned DATA_W   = wreg_pkg::DATA_W,
    parameter int unsigned GPR_N    = wreg_pkg::GPR_N,
    parameter int unsigned PTR_N    = wreg_pkg::PTR_N,
    parameter int unsigned GPR_AW   = $clog2(GPR_N),
    parameter int unsigned PTR_BASE = GPR_N - 2 * PTR_N
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [GPR_AW-1:0]                rd_a_idx,
    output logic [DATA_W-1:0]                rd_a_val,
    input  logic [GPR_AW-1:0]                rd_b_idx,
    output logic [DATA_W-1:0]                rd_b_val,
    input  logic [GPR_AW-1:0]                rd_c_idx,
    output logic [DATA_W-1:0]                rd_c_val,
    input  logic                             alu_we,
    input  logic [GPR_AW-1:0]                alu_idx,
    input  logic [DATA_W-1:0]                alu_val,
    input  logic                             ds_we,
    input  logic [GPR_AW-1:0]                ds_idx,
    input  logic [DATA_W-1:0]                ds_wdata,
    input  logic                             ptr_we,
    input  logic [1:0]                       ptr_sel,
    input  logic [2*DATA_W-1:0]              ptr_val,
    output logic [PTR_N-1:0][2*DATA_W-1:0]   ptr_out
);
    typedef struct packed {
        logic [GPR_N-1:0][DATA_W-1:0] r;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // lowest priority: data-space store
        if (ds_we) begin
            st_d.r[ds_idx] = ds_wdata;
        end
        // middle priority: 16-bit pointer update, both bytes together
        if (ptr_we) begin
            for (int k = 0; k < int'(PTR_N); k++) begin
                if (ptr_sel == 2'(k)) begin
                    st_d.r[PTR_BASE + 2 * k]     = ptr_val[DATA_W-1:0];
                    st_d.r[PTR_BASE + 2 * k + 1] = ptr_val[2*DATA_W-1:DATA_W];
                end
            end
        end
        // highest priority: ALU write-back
        if (alu_we) begin
            st_d.r[alu_idx] = alu_val;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_a_val = st_q.r[rd_a_idx];
    assign rd_b_val = st_q.r[rd_b_idx];
    assign rd_c_val = st_q.r[rd_c_idx];

    for (genvar k = 0; k < int'(PTR_N); k++) begin : g_ptr
        assign ptr_out[k] = {st_q.r[PTR_BASE + 2 * k + 1], st_q.r[PTR_BASE + 2 * k]};
    end
endmodule

// File: rtl/wreg_io_bank.sv
module wreg_io_bank #(
    parameter int unsigned DATA_W = wreg_pkg::DATA_W,
    parameter int unsigned IO_N   = wreg_pkg::IO_N,
    parameter int unsigned IO_AW  = $clog2(IO_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ds_we,
    input  logic [IO_AW-1:0]  ds_idx,
    input  logic [DATA_W-1:0] ds_wdata,
    output logic [DATA_W-1:0] ds_val,
    input  logic              io_we,
    input  logic [IO_AW-1:0]  io_idx,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_val
);
    typedef struct packed {
        logic [IO_N-1:0][DATA_W-1:0] r;
    } window_t;

    window_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ds_we) begin
            st_d.r[ds_idx] = ds_wdata;
        end
        // direct port overrides a colliding data-space store
        if (io_we) begin
            st_d.r[io_idx] = io_wdata;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ds_val = st_q.r[ds_idx];
    assign io_val = st_q.r[io_idx];
endmodule

// File: rtl/wreg_file.sv
module wreg_file
    import wreg_pkg::*;
#(
    parameter int unsigned DATA_W = wreg_pkg::DATA_W,
    parameter int unsigned GPR_N  = wreg_pkg::GPR_N,
    parameter int unsigned IO_N   = wreg_pkg::IO_N,
    parameter int unsigned DS_AW  = wreg_pkg::DS_AW,
    parameter int unsigned PTR_N  = wreg_pkg::PTR_N,
    parameter int unsigned GPR_AW = $clog2(GPR_N),
    parameter int unsigned IO_AW  = $clog2(IO_N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [GPR_AW-1:0]   rd_a_idx,
    output logic [DATA_W-1:0]   rd_a_val,
    input  logic [GPR_AW-1:0]   rd_b_idx,
    output logic [DATA_W-1:0]   rd_b_val,
    input  logic                alu_we,
    input  logic [GPR_AW-1:0]   alu_idx,
    input  logic [DATA_W-1:0]   alu_val,
    input  logic                ds_en,
    input  logic                ds_we,
    input  logic [DS_AW-1:0]    ds_addr,
    input  logic [DATA_W-1:0]   ds_wdata,
    output logic [DATA_W-1:0]   ds_rdata,
    output logic                ds_ext_sel,
    input  logic                io_we,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic [DATA_W-1:0]   io_wdata,
    output logic [DATA_W-1:0]   io_rdata,
    input  logic                ptr_we,
    input  logic [1:0]          ptr_sel,
    input  logic [2*DATA_W-1:0] ptr_val,
    output logic [2*DATA_W-1:0] ptr_x,
    output logic [2*DATA_W-1:0] ptr_y,
    output logic [2*DATA_W-1:0] ptr_z
);
    ds_region_t                    region;
    logic [GPR_AW-1:0]             ds_gpr_idx;
    logic [IO_AW-1:0]              ds_io_idx;
    logic [DATA_W-1:0]             ds_gpr_val;
    logic [DATA_W-1:0]             ds_io_val;
    logic                          ds_wr;
    logic [PTR_N-1:0][2*DATA_W-1:0] ptr_all;

    assign ds_wr = ds_en & ds_we;

    wreg_ds_decode #(
        .GPR_N (GPR_N),
        .IO_N  (IO_N),
        .DS_AW (DS_AW),
        .GPR_AW(GPR_AW),
        .IO_AW (IO_AW)
    ) u_decode (
        .ds_en  (ds_en),
        .ds_addr(ds_addr),
        .region (region),
        .gpr_idx(ds_gpr_idx),
        .io_idx (ds_io_idx)
    );

    wreg_gpr_bank #(
        .DATA_W(DATA_W),
        .GPR_N (GPR_N),
        .PTR_N (PTR_N),
        .GPR_AW(GPR_AW)
    ) u_gpr (
        .clk     (clk),
        .rst     (rst),
        .rd_a_idx(rd_a_idx),
        .rd_a_val(rd_a_val),
        .rd_b_idx(rd_b_idx),
        .rd_b_val(rd_b_val),
        .rd_c_idx(ds_gpr_idx),
        .rd_c_val(ds_gpr_val),
        .alu_we  (alu_we),
        .alu_idx (alu_idx),
        .alu_val (alu_val),
        .ds_we   (ds_wr & region.hit_gpr),
        .ds_idx  (ds_gpr_idx),
        .ds_wdata(ds_wdata),
        .ptr_we  (ptr_we),
        .ptr_sel (ptr_sel),
        .ptr_val (ptr_val),
        .ptr_out (ptr_all)
    );

    wreg_io_bank #(
        .DATA_W(DATA_W),
        .IO_N  (IO_N),
        .IO_AW (IO_AW)
    ) u_io (
        .clk     (clk),
        .rst     (rst),
        .ds_we   (ds_wr & region.hit_io),
        .ds_idx  (ds_io_idx),
        .ds_wdata(ds_wdata),
        .ds_val  (ds_io_val),
        .io_we   (io_we),
        .io_idx  (io_addr),
        .io_wdata(io_wdata),
        .io_val  (io_rdata)
    );

    always_comb begin
        ds_rdata = '0;
        if (region.hit_gpr) begin
            ds_rdata = ds_gpr_val;
        end else if (region.hit_io) begin
            ds_rdata = ds_io_val;
        end
    end

    assign ds_ext_sel = region.hit_ext;
    assign ptr_x      = ptr_all[PTR_X];
    assign ptr_y      = ptr_all[PTR_Y];
    assign ptr_z      = ptr_all[PTR_Z];
endmodule

// File: rtl/wreg_file_chk.sv
module wreg_file_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned GPR_N  = 32,
    parameter int unsigned DS_AW  = 16,
    parameter int unsigned IO_N   = 64,
    parameter int unsigned GPR_AW = 5,
    parameter int unsigned IO_AW  = 6
) (
    input logic                clk,
    input logic                rst,
    input logic [GPR_AW-1:0]   rd_a_idx,
    input logic [DATA_W-1:0]   rd_a_val,
    input logic [DATA_W-1:0]   rd_b_val,
    input logic                alu_we,
    input logic [GPR_AW-1:0]   alu_idx,
    input logic [DATA_W-1:0]   alu_val,
    input logic                ds_en,
    input logic [DS_AW-1:0]    ds_addr,
    input logic [DATA_W-1:0]   ds_rdata,
    input logic                ds_ext_sel,
    input logic [IO_AW-1:0]    io_addr,
    input logic [DATA_W-1:0]   io_rdata,
    input logic                ptr_we,
    input logic [1:0]          ptr_sel,
    input logic [2*DATA_W-1:0] ptr_val,
    input logic [2*DATA_W-1:0] ptr_x,
    input logic [2*DATA_W-1:0] ptr_z
);
    localparam logic [GPR_AW-1:0] X_LO   = GPR_AW'(GPR_N - 6);
    localparam logic [GPR_AW-1:0] Z_LO   = GPR_AW'(GPR_N - 2);
    localparam logic [DS_AW-1:0]  IO_LO  = DS_AW'(GPR_N);
    localparam logic [DS_AW-1:0]  EXT_LO = DS_AW'(GPR_N + IO_N);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_val == '0 && rd_b_val == '0));

    p_alu_writeback_r3: assert property (@(posedge clk) disable iff (rst)
        alu_we |=> (rd_a_idx != $past(alu_idx)) || (rd_a_val == $past(alu_val)));

    p_io_alias_r5: assert property (@(posedge clk) disable iff (rst)
        (ds_addr >= IO_LO && ds_addr < EXT_LO && (DS_AW'(io_addr) + IO_LO) == ds_addr)
        |-> ds_rdata == io_rdata);

    p_ext_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
        ds_ext_sel |-> ds_rdata == '0);

    p_ext_needs_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !ds_en |-> !ds_ext_sel);

    p_ptr_low_byte_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == X_LO) |-> rd_a_val == ptr_x[DATA_W-1:0]);

    p_ptr_pair_write_r8: assert property (@(posedge clk) disable iff (rst)
        (ptr_we && ptr_sel == 2'd2 && !(alu_we && alu_idx >= Z_LO))
        |=> ptr_z == $past(ptr_val));
endmodule

bind wreg_file wreg_file_chk #(
    .DATA_W(DATA_W),
    .GPR_N (GPR_N),
    .DS_AW (DS_AW),
    .IO_N  (IO_N),
    .GPR_AW(GPR_AW),
    .IO_AW (IO_AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_a_idx  (rd_a_idx),
    .rd_a_val  (rd_a_val),
    .rd_b_val  (rd_b_val),
    .alu_we    (alu_we),
    .alu_idx   (alu_idx),
    .alu_val   (alu_val),
    .ds_en     (ds_en),
    .ds_addr   (ds_addr),
    .ds_rdata  (ds_rdata),
    .ds_ext_sel(ds_ext_sel),
    .io_addr   (io_addr),
    .io_rdata  (io_rdata),
    .ptr_we    (ptr_we),
    .ptr_sel   (ptr_sel),
    .ptr_val   (ptr_val),
    .ptr_x     (ptr_x),
    .ptr_z     (ptr_z)
);

// File: tb/wreg_file_tb.sv
`timescale 1ns/1ps
module wreg_file_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_a_idx, rd_b_idx, alu_idx;
    logic [7:0]  rd_a_val, rd_b_val, alu_val;
    logic        alu_we, ds_en, ds_we, ds_ext_sel, io_we, ptr_we;
    logic [15:0] ds_addr, ptr_val, ptr_x, ptr_y, ptr_z;
    logic [7:0]  ds_wdata, ds_rdata, io_wdata, io_rdata;
    logic [5:0]  io_addr;
    logic [1:0]  ptr_sel;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    logic [7:0] m_gpr [32];
    logic [7:0] m_io  [64];

    always #4 clk = ~clk;

    wreg_file u_dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_val(rd_a_val),
        .rd_b_idx(rd_b_idx), .rd_b_val(rd_b_val),
        .alu_we(alu_we), .alu_idx(alu_idx), .alu_val(alu_val),
        .ds_en(ds_en), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .ds_ext_sel(ds_ext_sel),
        .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_val(ptr_val),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_ds();
        if (ds_addr < 16'h20) return m_gpr[ds_addr[4:0]];
        if (ds_addr < 16'h60) return m_io[6'(ds_addr - 16'h20)];
        return 8'h00;
    endfunction

    task automatic compare(input string req);
        chk(req, "rd_a_val", 16'(rd_a_val), 16'(m_gpr[rd_a_idx]));
        chk(req, "rd_b_val", 16'(rd_b_val), 16'(m_gpr[rd_b_idx]));
        chk(req, "ds_rdata", 16'(ds_rdata), 16'(exp_ds()));
        chk(req, "ds_ext_sel", 16'(ds_ext_sel), 16'(ds_en && ds_addr >= 16'h60));
        chk(req, "io_rdata", 16'(io_rdata), 16'(m_io[io_addr]));
        chk(req, "ptr_x", ptr_x, {m_gpr[27], m_gpr[26]});
        chk(req, "ptr_y", ptr_y, {m_gpr[29], m_gpr[28]});
        chk(req, "ptr_z", ptr_z, {m_gpr[31], m_gpr[30]});
    endtask

    // Behavioural model: later statements overwrite earlier ones, giving the required priority.
    task automatic model_edge();
        if (rst) begin
            foreach (m_gpr[i]) m_gpr[i] = 8'h00;
            foreach (m_io[i])  m_io[i]  = 8'h00;
        end else begin
            if (ds_en && ds_we) begin
                if (ds_addr < 16'h20)      m_gpr[ds_addr[4:0]] = ds_wdata;
                else if (ds_addr < 16'h60) m_io[6'(ds_addr - 16'h20)] = ds_wdata;
            end
            if (ptr_we && ptr_sel != 2'd3) begin
                m_gpr[26 + 2 * int'(ptr_sel)] = ptr_val[7:0];
                m_gpr[27 + 2 * int'(ptr_sel)] = ptr_val[15:8];
            end
            if (alu_we) m_gpr[alu_idx] = alu_val;
            if (io_we)  m_io[io_addr] = io_wdata;
        end
    endtask

    task automatic cycle(input string req);
        #1;
        if (cmp_on) compare(req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 1'b0; alu_we = 1'b0; ds_en = 1'b0; ds_we = 1'b0; io_we = 1'b0; ptr_we = 1'b0;
        rd_a_idx = '0; rd_b_idx = '0; alu_idx = '0; alu_val = '0;
        ds_addr = '0; ds_wdata = '0; io_addr = '0; io_wdata = '0;
        ptr_sel = 2'd3; ptr_val = '0;
    endtask

    task automatic ds_write(input logic [15:0] a, input logic [7:0] d);
        ds_en = 1'b1; ds_we = 1'b1; ds_addr = a; ds_wdata = d;
    endtask

    initial begin
        idle();
        rst = 1'b1;
        foreach (m_gpr[i]) m_gpr[i] = 8'h00;
        foreach (m_io[i])  m_io[i]  = 8'h00;
        repeat (3) cycle("R1");
        rst = 1'b0;
        cmp_on = 1'b1;
        cycle("R1");

        // R3 and R11: same-cycle read sees old value, next cycle sees new
        idle(); rd_a_idx = 5'd5; rd_b_idx = 5'd5; alu_we = 1'b1; alu_idx = 5'd5; alu_val = 8'hA5;
        ds_addr = 16'h0005; ds_en = 1'b1;
        cycle("R11");
        idle(); rd_a_idx = 5'd5; ds_en = 1'b1; ds_addr = 16'h0005;
        cycle("R3");

        // R4: data-space store to the top working register, read at both boundaries
        idle(); ds_write(16'h001F, 8'h3C); cycle("R4");
        idle(); ds_en = 1'b1; ds_addr = 16'h001F; rd_a_idx = 5'd31; cycle("R4");

        // R5: window boundaries 0x20 and 0x5F, direct port aliasing
        idle(); ds_write(16'h0020, 8'h11); cycle("R5");
        idle(); ds_write(16'h005F, 8'h22); io_addr = 6'd0; cycle("R5");
        idle(); io_addr = 6'd63; ds_en = 1'b1; ds_addr = 16'h0020; cycle("R5");
        idle(); io_we = 1'b1; io_addr = 6'd10; io_wdata = 8'h77; cycle("R5");
        idle(); ds_en = 1'b1; ds_addr = 16'h002A; cycle("R5");

        // R6: external region writes change nothing, select follows strobe
        idle(); ds_write(16'h0060, 8'hEE); cycle("R6");
        idle(); ds_write(16'hFFFF, 8'hDD); cycle("R6");
        idle(); ds_addr = 16'h0060; cycle("R6");
        idle(); ds_en = 1'b1; ds_addr = 16'h0000; cycle("R6");

        // R7 and R8: pointer writes of both bytes, unused selector ignored
        idle(); ptr_we = 1'b1; ptr_sel = 2'd0; ptr_val = 16'hBEEF; cycle("R8");
        idle(); rd_a_idx = 5'd26; rd_b_idx = 5'd27; cycle("R7");
        idle(); ptr_we = 1'b1; ptr_sel = 2'd2; ptr_val = 16'h1234; cycle("R8");
        idle(); ptr_we = 1'b1; ptr_sel = 2'd3; ptr_val = 16'hFFFF; cycle("R8");
        idle(); rd_a_idx = 5'd30; rd_b_idx = 5'd31; cycle("R8");

        // R9: collisions on one register
        idle(); alu_we = 1'b1; alu_idx = 5'd7; alu_val = 8'h11; ds_write(16'h0007, 8'h22); cycle("R9");
        idle(); rd_a_idx = 5'd7; cycle("R9");
        idle(); ptr_we = 1'b1; ptr_sel = 2'd1; ptr_val = 16'hC0DE;
        alu_we = 1'b1; alu_idx = 5'd29; alu_val = 8'h5A; ds_write(16'h001C, 8'h99); cycle("R9");
        idle(); rd_a_idx = 5'd28; rd_b_idx = 5'd29; cycle("R9");
        idle(); ptr_we = 1'b1; ptr_sel = 2'd1; ptr_val = 16'h4321; ds_write(16'h001D, 8'h66); cycle("R9");
        idle(); rd_a_idx = 5'd29; cycle("R9");

        // R10: direct I/O beats data-space on the same I/O register
        idle(); io_we = 1'b1; io_addr = 6'd3; io_wdata = 8'h33; ds_write(16'h0023, 8'h44); cycle("R10");
        idle(); io_addr = 6'd3; ds_en = 1'b1; ds_addr = 16'h0023; cycle("R10");

        // Mixed random traffic covering R2 R4 R5 R7 R9 R10
        for (int n = 0; n < 4000; n++) begin
            rst      = ($urandom % 600) == 0;
            rd_a_idx = 5'($urandom); rd_b_idx = 5'($urandom);
            alu_we   = ($urandom % 3) == 0; alu_idx = 5'($urandom); alu_val = 8'($urandom);
            ds_en    = ($urandom % 4) != 0; ds_we = ($urandom % 2) == 0;
            ds_addr  = (($urandom % 8) == 0) ? 16'($urandom) : 16'($urandom % 128);
            ds_wdata = 8'($urandom);
            io_we    = ($urandom % 4) == 0; io_addr = 6'($urandom); io_wdata = 8'($urandom);
            ptr_we   = ($urandom % 4) == 0; ptr_sel = 2'($urandom); ptr_val = 16'($urandom);
            if (($urandom % 5) == 0) begin
                ds_addr = 16'h001A + 16'($urandom % 6);
                alu_idx = 5'(26 + ($urandom % 6));
            end
            cycle("R2 R4 R5 R7 R9 R10");
        end

        // R1: dirty state then reset, sweep everything back
        idle(); rst = 1'b1; cycle("R1");
        for (int i = 0; i < 64; i++) begin
            idle(); rd_a_idx = 5'(i); rd_b_idx = 5'(31 - (i % 32)); io_addr = 6'(i);
            ds_en = 1'b1; ds_addr = 16'(i + 32);
            cycle("R1");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule